// File: doc/BRIEF.md
# Region-Based Address Security Filter

This block sits beside a memory port and decides, for every transaction, whether it may proceed. Software programs up to eight bounded address regions plus one background region. Each region carries a secure-side read/write attribute, a per-filter enable mask and a 32-bit permission word for non-secure masters. A transaction presents its address, direction, security state, a 4-bit non-secure master ID and the index of the filter it arrived on. One cycle later the block answers with either a permit or a fault.

Region 0 has no bounds. It matches every address on every filter and supplies the default answer when no bounded region applies. Bounded regions compare on 4 KB pages, with the top page inclusive. When bounded regions overlap, the highest-numbered matching region decides. On a fault, a global action setting chooses whether an error response, an interrupt request, both or neither go out with the fault pulse. The first faulting address, direction and ID are held in status outputs until software clears them.

Top module: `addr_guard`

## Requirements
- R1: After reset no response is valid, `fault_valid` is 0, the fault action is error-only, and every bounded region is inactive. Region 0 grants nothing, so every access is denied.
- R2: Region 0 matches every address on every filter. Its attribute and permission word decide any access that no bounded region matches.
- R3: A bounded region (1 to NUM_REGIONS-1) matches when the address page (address bits 12 and up) lies between its base page and top page, both inclusive. It also needs attribute bit 16+f set for the transaction's filter index f. Address bits 11:0 are ignored.
- R4: When several bounded regions match, the highest-numbered one alone decides.
- R5: A secure access is allowed when the deciding region's attribute bit 1 (writes) or bit 0 (reads) is set.
- R6: A non-secure access with ID i is allowed when bit i (reads) or bit 16+i (writes) of the deciding region's permission word is set.
- R7: A request accepted on one clock edge is answered on the next edge. `resp_valid` is high for one cycle with exactly one of `resp_permit` or `resp_fault`. Nothing is asserted when no request was accepted.
- R8: The action setting (2 bits: 0 none, 1 error, 2 interrupt, 3 both) drives `resp_err` from bit 0 and `resp_irq` from bit 1, and only in a fault cycle. The action is written in bits 1:0 of word 0.
- R9: The first fault loads `fault_valid`, `fault_addr`, `fault_write` and `fault_id` in the same edge as the fault pulse. Later faults leave them unchanged. Any write to word 1 clears `fault_valid` on the next edge.
- R10: Configuration word address = region*8 + slot. The slots are: 0 base low, 1 base high, 2 top low, 3 top high, 4 attribute, 5 permission. Base and top form a 64-bit byte address from the low and high words. For region 0, only slots 4 and 5 apply, and slots 0 and 1 are the action and clear words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Transaction present |
| req_addr | input | ADDR_W | Transaction byte address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_secure | input | 1 | 1 for a secure access |
| req_id | input | 4 | Non-secure master ID |
| req_filter | input | FLT_W | Filter index the transaction arrived on |
| resp_valid | output | 1 | Decision present |
| resp_permit | output | 1 | Access allowed |
| resp_fault | output | 1 | Access denied (one-cycle pulse) |
| resp_err | output | 1 | Error response requested for the fault |
| resp_irq | output | 1 | Interrupt requested for the fault |
| fault_valid | output | 1 | Fault status holds a captured fault |
| fault_addr | output | ADDR_W | Address of the captured fault |
| fault_write | output | 1 | Direction of the captured fault |
| fault_id | output | 4 | Master ID of the captured fault |

## Verification
The bench probes the last and first byte of a region's top page and the page just past it. An exclusive top or a compare that includes the low 12 bits would permit or deny the wrong edge. It builds overlaps where a higher region must override a lower one, so a lowest-wins or OR-combined resolution shows up as a flipped answer. It also issues accesses on a filter whose enable bit is clear, which a design that ignored the filter mask would deny. Status is stressed with back-to-back faults and clears: a design that overwrote the capture, or failed to clear it, would report a wrong address or a stale valid flag.

// File: rtl/addr_guard_pkg.sv
package addr_guard_pkg;

    localparam int SLOT_W  = 3;
    localparam int ID_W    = 4;
    localparam int FEN_LSB = 16;
    localparam int WR_OFS  = 16;

    localparam logic [SLOT_W-1:0] SL_BASE_LO = 3'd0;
    localparam logic [SLOT_W-1:0] SL_BASE_HI = 3'd1;
    localparam logic [SLOT_W-1:0] SL_TOP_LO  = 3'd2;
    localparam logic [SLOT_W-1:0] SL_TOP_HI  = 3'd3;
    localparam logic [SLOT_W-1:0] SL_ATTR    = 3'd4;
    localparam logic [SLOT_W-1:0] SL_PERM    = 3'd5;
    localparam logic [SLOT_W-1:0] SL_ACTION  = 3'd0;
    localparam logic [SLOT_W-1:0] SL_CLEAR   = 3'd1;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_ERR  = 2'd1,
        ACT_IRQ  = 2'd2,
        ACT_BOTH = 2'd3
    } action_e;

endpackage

// File: rtl/addr_guard_regs.sv
module addr_guard_regs
    import addr_guard_pkg::*;
#(
    parameter int NR     = 9,
    parameter int NF     = 4,
    parameter int ADDR_W = 40,
    parameter int CFG_AW = 7
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_we,
    input  logic [CFG_AW-1:0]                cfg_addr,
    input  logic [31:0]                      cfg_wdata,
    output logic [NR-1:1][ADDR_W-13:0]       base_pg,
    output logic [NR-1:1][ADDR_W-13:0]       top_pg,
    output logic [NR-1:1][NF-1:0]            fen,
    output logic [NR-1:0][1:0]               sec,
    output logic [NR-1:0][31:0]              perm,
    output logic [1:0]                       action,
    output logic                             clr_status
);

    localparam int PG_W = ADDR_W - 12;
    localparam int RI_W = CFG_AW - SLOT_W;

    typedef struct packed {
        logic [NR-1:1][PG_W-1:0] base;
        logic [NR-1:1][PG_W-1:0] top;
        logic [NR-1:1][NF-1:0]   fen;
        logic [NR-1:0][1:0]      sec;
        logic [NR-1:0][31:0]     perm;
        logic [1:0]              action;
    } cfg_t;

    cfg_t              cfg_d, cfg_q;
    logic              clr_d;
    logic [RI_W-1:0]   ridx;
    logic [SLOT_W-1:0] slot;

    function automatic logic [PG_W-1:0] merge_word(logic [PG_W-1:0] cur,
                                                   logic hi, logic [31:0] w);
        logic [63:0] full;
        full = 64'(cur) << 12;
        if (hi) full[63:32] = w;
        else    full[31:0]  = w;
        return full[ADDR_W-1:12];
    endfunction

    always_comb begin
        cfg_d = cfg_q;
        clr_d = 1'b0;
        ridx  = cfg_addr[CFG_AW-1:SLOT_W];
        slot  = cfg_addr[SLOT_W-1:0];
        if (cfg_we && (int'(ridx) < NR)) begin
            if (ridx == '0) begin
                case (slot)
                    SL_ACTION: cfg_d.action  = cfg_wdata[1:0];
                    SL_CLEAR:  clr_d         = 1'b1;
                    SL_ATTR:   cfg_d.sec[0]  = cfg_wdata[1:0];
                    SL_PERM:   cfg_d.perm[0] = cfg_wdata;
                    default: ;
                endcase
            end else begin
                case (slot)
                    SL_BASE_LO, SL_BASE_HI:
                        cfg_d.base[ridx] = merge_word(cfg_q.base[ridx], slot[0], cfg_wdata);
                    SL_TOP_LO, SL_TOP_HI:
                        cfg_d.top[ridx]  = merge_word(cfg_q.top[ridx], slot[0], cfg_wdata);
                    SL_ATTR: begin
                        cfg_d.sec[ridx] = cfg_wdata[1:0];
                        cfg_d.fen[ridx] = cfg_wdata[FEN_LSB +: NF];
                    end
                    SL_PERM: cfg_d.perm[ridx] = cfg_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q        <= '0;
            cfg_q.action <= ACT_ERR;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign base_pg    = cfg_q.base;
    assign top_pg     = cfg_q.top;
    assign fen        = cfg_q.fen;
    assign sec        = cfg_q.sec;
    assign perm       = cfg_q.perm;
    assign action     = cfg_q.action;
    assign clr_status = clr_d;

    AST_ATTR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr[SLOT_W-1:0] == SL_ATTR && int'(cfg_addr[CFG_AW-1:SLOT_W]) < NR)
        |=> sec[$past(cfg_addr[CFG_AW-1:SLOT_W])] == $past(cfg_wdata[1:0])); // R10

    AST_ACTION_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == CFG_AW'(0))
        |=> action == $past(cfg_wdata[1:0])); // R8

endmodule

// File: rtl/addr_guard_match.sv
module addr_guard_match #(
    parameter int NR     = 9,
    parameter int NF     = 4,
    parameter int ADDR_W = 40,
    parameter int FLT_W  = 2,
    parameter int WIN_W  = 4
) (
    input  logic [ADDR_W-13:0]          addr_pg,
    input  logic [FLT_W-1:0]            filter,
    input  logic [NR-1:1][ADDR_W-13:0]  base_pg,
    input  logic [NR-1:1][ADDR_W-13:0]  top_pg,
    input  logic [NR-1:1][NF-1:0]       fen,
    output logic [WIN_W-1:0]            win
);

    logic [NR-1:1] hit;

    for (genvar r = 1; r < NR; r++) begin : g_cmp
        assign hit[r] = fen[r][filter]
                     && (addr_pg >= base_pg[r])
                     && (addr_pg <= top_pg[r]);
    end

    always_comb begin
        win = '0;
        for (int r = 1; r < NR; r++) begin
            if (hit[r]) win = WIN_W'(r);
        end
    end

endmodule

// File: rtl/addr_guard.sv
module addr_guard
    import addr_guard_pkg::*;
#(
    parameter int NUM_REGIONS = 9,
    parameter int NUM_FILTERS = 4,
    parameter int ADDR_W      = 40,
    parameter int CFG_AW      = $clog2(NUM_REGIONS * 8),
    parameter int FLT_W       = (NUM_FILTERS > 1) ? $clog2(NUM_FILTERS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_secure,
    input  logic [3:0]        req_id,
    input  logic [FLT_W-1:0]  req_filter,
    output logic              resp_valid,
    output logic              resp_permit,
    output logic              resp_fault,
    output logic              resp_err,
    output logic              resp_irq,
    output logic              fault_valid,
    output logic [ADDR_W-1:0] fault_addr,
    output logic              fault_write,
    output logic [3:0]        fault_id
);

    localparam int PG_W  = ADDR_W - 12;
    localparam int WIN_W = $clog2(NUM_REGIONS);

    logic [NUM_REGIONS-1:1][PG_W-1:0]        base_pg, top_pg;
    logic [NUM_REGIONS-1:1][NUM_FILTERS-1:0] fen;
    logic [NUM_REGIONS-1:0][1:0]             sec;
    logic [NUM_REGIONS-1:0][31:0]            perm;
    logic [1:0]                              action;
    logic                                    clr_status;
    logic [WIN_W-1:0]                        win;

    addr_guard_regs #(
        .NR(NUM_REGIONS), .NF(NUM_FILTERS), .ADDR_W(ADDR_W), .CFG_AW(CFG_AW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .base_pg(base_pg), .top_pg(top_pg), .fen(fen),
        .sec(sec), .perm(perm), .action(action), .clr_status(clr_status)
    );

    addr_guard_match #(
        .NR(NUM_REGIONS), .NF(NUM_FILTERS), .ADDR_W(ADDR_W),
        .FLT_W(FLT_W), .WIN_W(WIN_W)
    ) u_match (
        .addr_pg(req_addr[ADDR_W-1:12]), .filter(req_filter),
        .base_pg(base_pg), .top_pg(top_pg), .fen(fen), .win(win)
    );

    typedef struct packed {
        logic              rv;
        logic              permit;
        logic              fault;
        logic              err;
        logic              irq;
        logic              fv;
        logic [ADDR_W-1:0] fa;
        logic              fw;
        logic [3:0]        fid;
    } st_t;

    st_t  st_d, st_q;
    logic [1:0]  win_sec;
    logic [31:0] win_perm;
    logic        allow;

    always_comb begin
        win_sec  = sec[win];
        win_perm = perm[win];
        allow    = req_secure ? win_sec[req_write]
                              : win_perm[{req_write, req_id}];
        st_d        = st_q;
        st_d.rv     = req_valid;
        st_d.permit = req_valid && allow;
        st_d.fault  = req_valid && !allow;
        st_d.err    = st_d.fault && action[0];
        st_d.irq    = st_d.fault && action[1];
        if (clr_status) st_d.fv = 1'b0;
        if (st_d.fault && (!st_q.fv || clr_status)) begin
            st_d.fv  = 1'b1;
            st_d.fa  = req_addr;
            st_d.fw  = req_write;
            st_d.fid = req_id;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign resp_valid  = st_q.rv;
    assign resp_permit = st_q.permit;
    assign resp_fault  = st_q.fault;
    assign resp_err    = st_q.err;
    assign resp_irq    = st_q.irq;
    assign fault_valid = st_q.fv;
    assign fault_addr  = st_q.fa;
    assign fault_write = st_q.fw;
    assign fault_id    = st_q.fid;

    AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_permit ^ resp_fault)); // R7

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> (!resp_permit && !resp_fault)); // R7

    AST_ACTION_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_err || resp_irq) |-> resp_fault); // R8

    AST_FAULT_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        resp_fault |-> fault_valid); // R9

    AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fault_valid) && !$past(clr_status))
        |-> (fault_valid && $stable(fault_addr) && $stable(fault_write)
             && $stable(fault_id))); // R9

endmodule

// File: tb/addr_guard_test.sv
module addr_guard_test;

    localparam int ADDR_W = 40;
    localparam int CFG_AW = 7;
    localparam int FLT_W  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [CFG_AW-1:0] cfg_addr = '0;
    logic [31:0]       cfg_wdata = '0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_write = 1'b0;
    logic              req_secure = 1'b0;
    logic [3:0]        req_id = '0;
    logic [FLT_W-1:0]  req_filter = '0;
    logic              resp_valid, resp_permit, resp_fault, resp_err, resp_irq;
    logic              fault_valid, fault_write;
    logic [ADDR_W-1:0] fault_addr;
    logic [3:0]        fault_id;

    addr_guard uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_secure(req_secure), .req_id(req_id),
        .req_filter(req_filter), .resp_valid(resp_valid),
        .resp_permit(resp_permit), .resp_fault(resp_fault),
        .resp_err(resp_err), .resp_irq(resp_irq), .fault_valid(fault_valid),
        .fault_addr(fault_addr), .fault_write(fault_write), .fault_id(fault_id)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;

    longint    mb [1:8];
    longint    mt [1:8];
    bit [3:0]  mf [1:8];
    bit [1:0]  ms [0:8];
    bit [31:0] mp [0:8];
    bit [1:0]  ma;
    bit        sfv;
    longint    sfa;
    bit        sfw;
    int        sfid;

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit model_allow(longint a, bit wr, bit sc, int id, int f);
        longint pg = a >>> 12;
        int w = 0;
        for (int r = 1; r <= 8; r++)
            if (mf[r][f] && pg >= mb[r] && pg <= mt[r]) w = r;
        if (sc) return ms[w][wr];
        return mp[w][(wr ? 16 : 0) + id];
    endfunction

    task automatic cfg_wr(int idx, int slot, bit [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = CFG_AW'(idx * 8 + slot);
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_region(int r, longint b, longint t, bit [3:0] f,
                              bit [1:0] s, bit [31:0] p);
        if (r != 0) begin
            cfg_wr(r, 0, b[31:0]);
            cfg_wr(r, 1, b[63:32]);
            cfg_wr(r, 2, t[31:0]);
            cfg_wr(r, 3, t[63:32]);
            mb[r] = b >>> 12;
            mt[r] = t >>> 12;
            mf[r] = f;
        end
        cfg_wr(r, 4, (32'(f) << 16) | 32'(s));
        cfg_wr(r, 5, p);
        ms[r] = s;
        mp[r] = p;
    endtask

    task automatic set_action(bit [1:0] a);
        cfg_wr(0, 0, 32'(a));
        ma = a;
    endtask

    task automatic clear_status();
        cfg_wr(0, 1, 32'h0);
        sfv = 1'b0;
        chk("R9 clear", fault_valid, 0);
    endtask

    task automatic req(longint a, bit wr, bit sc, int id, int f, string tag);
        bit exp = model_allow(a, wr, sc, id, f);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr = a[ADDR_W-1:0];
        req_write = wr;
        req_secure = sc;
        req_id = 4'(id);
        req_filter = FLT_W'(f);
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R7 valid"}, resp_valid, 1);
        chk({tag, " permit"}, resp_permit, exp);
        chk({tag, " fault"}, resp_fault, !exp);
        chk({tag, " R8 err"}, resp_err, !exp && ma[0]);
        chk({tag, " R8 irq"}, resp_irq, !exp && ma[1]);
        if (!exp && !sfv) begin
            sfv = 1'b1; sfa = a; sfw = wr; sfid = id;
        end
        chk({tag, " R9 fv"}, fault_valid, sfv);
        if (sfv) begin
            chk({tag, " R9 addr"}, longint'(fault_addr), sfa);
            chk({tag, " R9 dir"}, fault_write, sfw);
            chk({tag, " R9 id"}, fault_id, sfid);
        end
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1207));
        for (int r = 1; r <= 8; r++) begin mb[r] = 0; mt[r] = 0; mf[r] = 0; end
        for (int r = 0; r <= 8; r++) begin ms[r] = 0; mp[r] = 0; end
        ma = 2'd1;
        sfv = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 resp_valid", resp_valid, 0);
        chk("R1 fault_valid", fault_valid, 0);
        chk("R1 resp_err", resp_err, 0);
        req(40'h00_1234_5678, 1'b0, 1'b1, 0, 0, "R1 deny-all");
        req(40'h00_0000_0000, 1'b1, 1'b0, 3, 2, "R1 deny-all ns");
        clear_status();

        // R2 background region
        set_region(0, 0, 0, 4'h0, 2'b11, 32'h0001_0001);
        req(40'h55_0000_0000, 1'b0, 1'b1, 0, 3, "R2 sec read");
        req(40'h00_0000_1000, 1'b0, 1'b0, 0, 1, "R2 R6 ns id0 read");
        req(40'h00_0000_1000, 1'b0, 1'b0, 1, 1, "R6 ns id1 denied");
        req(40'h00_0000_1000, 1'b1, 1'b0, 0, 1, "R6 ns id0 write");

        // R3 inclusive bounds and filter mask
        set_region(3, 40'h2000, 40'h4FFF, 4'b0001, 2'b00, 32'h0);
        req(40'h4FFF, 1'b0, 1'b1, 0, 0, "R3 top byte");
        req(40'h4000, 1'b0, 1'b1, 0, 0, "R3 top page start");
        req(40'h5000, 1'b0, 1'b1, 0, 0, "R3 past top");
        req(40'h1FFF, 1'b0, 1'b1, 0, 0, "R3 below base");
        req(40'h2000, 1'b0, 1'b1, 0, 0, "R3 base");
        req(40'h3000, 1'b0, 1'b1, 0, 1, "R3 filter off");

        // R4 priority
        set_region(6, 40'h3000, 40'h3FFF, 4'b0001, 2'b11, 32'h0);
        req(40'h3800, 1'b0, 1'b1, 0, 0, "R4 higher wins");
        req(40'h2800, 1'b0, 1'b1, 0, 0, "R4 lower only");

        // R5 R10 high word and write-only secure attribute
        set_region(7, 40'h12_0000_0000, 40'h12_0000_0FFF, 4'hF, 2'b10, 32'h0004_0000);
        req(40'h12_0000_0800, 1'b1, 1'b1, 0, 2, "R5 R10 sec write");
        req(40'h12_0000_0800, 1'b0, 1'b1, 0, 2, "R5 sec read denied");
        req(40'h12_0000_0800, 1'b1, 1'b0, 2, 2, "R6 ns id2 write");
        req(40'h12_0000_0800, 1'b0, 1'b0, 2, 2, "R6 ns id2 read denied");
        req(40'h13_0000_0800, 1'b0, 1'b1, 0, 2, "R10 high word differs");

        // R9 hold then clear, R8 actions
        clear_status();
        req(40'h2004, 1'b1, 1'b1, 5, 0, "R9 first fault");
        req(40'h2008, 1'b0, 1'b1, 6, 0, "R9 second fault held");
        clear_status();
        for (int a = 0; a < 4; a++) begin
            set_action(2'(a));
            req(40'h2010, 1'b0, 1'b1, a, 0, "R8 action");
        end

        // random mix
        for (int i = 0; i < 400; i++) begin
            int k = $urandom_range(0, 9);
            if (k == 0) begin
                int r = $urandom_range(0, 8);
                longint b = longint'($urandom_range(0, 63));
                longint t = b + longint'($urandom_range(0, 15));
                set_region(r, b << 12, (t << 12) | 'hFFF, 4'($urandom_range(0, 15)),
                           2'($urandom_range(0, 3)), $urandom());
            end else if (k == 1) begin
                set_action(2'($urandom_range(0, 3)));
            end else if (k == 2) begin
                clear_status();
            end else begin
                longint a = (longint'($urandom_range(0, 80)) << 12)
                          | longint'($urandom_range(0, 4095));
                req(a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    $urandom_range(0, 15), $urandom_range(0, 3), "R3 R4 R5 R6 random");
            end
        end

        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule